// File: doc/BRIEF.md
# CAN Controller Mode and Interrupt Control

This block is the register-level control core of a CAN node. Software reaches it through a 32-bit memory-mapped write port with a combinational read-back. The registers are a control word that holds the enable bit, a mode request register, a one-hot status register, an interrupt flag register and a write-one-to-clear register. The core holds the node in configuration mode until it is enabled. On enable it applies the latched mode request: normal, loopback, snoop or sleep. A simplified frame engine beside it reports traffic through three single-cycle strobes: a frame was sent, a frame was received, and activity was seen on the bus.

The core decides which of these events count in the current mode. It raises the transmit-done and receive-done flags from the events that count. It tells the frame engine whether it may drive the bus and whether transmitted frames must be turned back to the node's own receiver. A sleeping node wakes into normal mode by itself when traffic appears on the bus. The interrupt line is the OR of the two flags.

Register offsets: control 0x00, mode 0x04, status 0x08, interrupt flags 0x0C, interrupt clear 0x10. Unmapped offsets and the clear register read as zero.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the node is disabled and in configuration mode. The control, status, mode and interrupt flag registers all read 0, and irq, tx_permit and loop_route are low.
- R2: The mode register takes the low three bits of the written value: bit 0 set requests sleep (reads back 0x01); otherwise bit 1 set requests loopback (0x02); otherwise bit 2 set requests snoop (0x04); no bit set requests normal (0x00).
- R3: The status register is one-hot by active mode: bit 3 for normal, bit 1 for loopback, bit 2 for sleep, bit 12 for snoop. It reads 0 in configuration mode.
- R4: Writing the control register with bit 1 set while disabled enables the node, and the status register shows the requested mode from the next cycle. Writing bit 1 clear disables the node and returns it to configuration mode. Control bit 1 reads back the enable state.
- R5: Writes to the mode register while the node is enabled are ignored: the mode read-back and the status register keep their values.
- R6: In sleep mode a bus_activity strobe moves the node to normal mode on the next cycle. An rx_done strobe in sleep mode sets the receive-done flag.
- R7: Interrupt flag bit 1 (transmit done) is set by tx_done in normal mode. Bit 4 (receive done) is set by rx_done in normal mode. In configuration mode both strobes are ignored.
- R8: In loopback mode tx_done sets both bit 1 and bit 4, external rx_done is ignored, and loop_route is high.
- R9: In snoop mode rx_done sets bit 4, tx_done is ignored, and tx_permit is low. tx_permit is high only in normal and loopback modes.
- R10: A write to the interrupt clear register clears each flag whose bit position is written as 1. Zero bits leave their flags unchanged.
- R11: When a counted event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R12: irq is high exactly when at least one interrupt flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Register byte offset for writes and reads |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for addr |
| tx_done | input | 1 | Frame engine: a frame was sent |
| rx_done | input | 1 | Frame engine: a frame was received |
| bus_activity | input | 1 | Frame engine: traffic seen on the bus |
| tx_permit | output | 1 | Node may drive the bus |
| loop_route | output | 1 | Transmitted frames go to the node's own receiver |
| irq | output | 1 | OR of the interrupt flags |

## Verification
Directed sequences take each mode through the disable, select and enable order. In each mode they apply tx_done, rx_done and bus_activity, which shows that every mode accepts or drops each strobe as required. Mode codes with several bits set separate the decode priority from a plain copy. A mode write while enabled separates locking from blind latching. A clear that coincides with an event separates set-wins from clear-wins. Constrained random runs then mix register writes with all three strobes, including disables during sleep and clears with partial masks. A bench model that follows the requirements predicts every register after each cycle.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;

    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_FLAG = 8'h0C;
    localparam logic [7:0] OFS_FCLR = 8'h10;

    localparam int EN_BIT    = 1;
    localparam int TXF_BIT   = 1;
    localparam int RXF_BIT   = 4;
    localparam int ST_NORMAL = 3;
    localparam int ST_LOOP   = 1;
    localparam int ST_SLEEP  = 2;
    localparam int ST_SNOOP  = 12;

    typedef enum logic [2:0] {
        OPM_CFG    = 3'd0,
        OPM_NORMAL = 3'd1,
        OPM_LOOP   = 3'd2,
        OPM_SNOOP  = 3'd3,
        OPM_SLEEP  = 3'd4
    } op_mode_e;

    typedef struct packed {
        logic tx;
        logic rx;
    } flag_set_t;

    function automatic op_mode_e decode_request(input logic [2:0] code);
        if (code[0])      return OPM_SLEEP;
        else if (code[1]) return OPM_LOOP;
        else if (code[2]) return OPM_SNOOP;
        else              return OPM_NORMAL;
    endfunction

    function automatic logic [2:0] encode_request(input op_mode_e m);
        case (m)
            OPM_SLEEP: return 3'b001;
            OPM_LOOP:  return 3'b010;
            OPM_SNOOP: return 3'b100;
            default:   return 3'b000;
        endcase
    endfunction

    function automatic logic [15:0] status_bits(input op_mode_e m);
        logic [15:0] s;
        s = '0;
        case (m)
            OPM_NORMAL: s[ST_NORMAL] = 1'b1;
            OPM_LOOP:   s[ST_LOOP]   = 1'b1;
            OPM_SLEEP:  s[ST_SLEEP]  = 1'b1;
            OPM_SNOOP:  s[ST_SNOOP]  = 1'b1;
            default:    s            = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic       ctrl_en_bit,
    input  logic       mode_wr,
    input  logic [2:0] mode_code,
    input  logic       bus_activity,
    output logic       enabled,
    output op_mode_e   active_mode,
    output op_mode_e   pend_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled     <= 1'b0;
            active_mode <= OPM_CFG;
            pend_mode   <= OPM_NORMAL;
        end else begin
            if (ctrl_wr) begin
                enabled <= ctrl_en_bit;
                if (!ctrl_en_bit)
                    active_mode <= OPM_CFG;
                else if (!enabled)
                    active_mode <= pend_mode;
            end else if (active_mode == OPM_SLEEP && bus_activity) begin
                active_mode <= OPM_NORMAL;
            end
            if (mode_wr && !enabled)
                pend_mode <= decode_request(mode_code);
        end
    end

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_ctl_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  op_mode_e          active_mode,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_mask,
    output flag_set_t         flags
);

    flag_set_t hit;
    flag_set_t kept;

    always_comb begin
        hit.tx = tx_done && (active_mode == OPM_NORMAL || active_mode == OPM_LOOP);
        hit.rx = (rx_done && (active_mode == OPM_NORMAL || active_mode == OPM_SLEEP ||
                              active_mode == OPM_SNOOP)) ||
                 (tx_done && active_mode == OPM_LOOP);
        kept.tx = flags.tx && !(clr_wr && clr_mask[TXF_BIT]);
        kept.rx = flags.rx && !(clr_wr && clr_mask[RXF_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.tx <= kept.tx || hit.tx;
            flags.rx <= kept.rx || hit.rx;
        end
    end

endmodule

// File: rtl/can_reg_read.sv
module can_reg_read
    import can_ctl_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              enabled,
    input  op_mode_e          pend_mode,
    input  logic [15:0]       status_word,
    input  flag_set_t         flags,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_CTRL): rdata[EN_BIT] = enabled;
            ADDR_W'(OFS_MODE): rdata[2:0]    = encode_request(pend_mode);
            ADDR_W'(OFS_STAT): rdata[15:0]   = status_word;
            ADDR_W'(OFS_FLAG): begin
                rdata[TXF_BIT] = flags.tx;
                rdata[RXF_BIT] = flags.rx;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_ctl_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic              bus_activity,
    output logic              tx_permit,
    output logic              loop_route,
    output logic              irq
);

    logic        ctrl_wr;
    logic        mode_wr;
    logic        clr_wr;
    logic        enabled;
    op_mode_e    active_mode;
    op_mode_e    pend_mode;
    flag_set_t   flags;
    logic [15:0] status_word;

    assign ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign mode_wr = wr_en && (addr == ADDR_W'(OFS_MODE));
    assign clr_wr  = wr_en && (addr == ADDR_W'(OFS_FCLR));

    can_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .ctrl_en_bit  (wdata[EN_BIT]),
        .mode_wr      (mode_wr),
        .mode_code    (wdata[2:0]),
        .bus_activity (bus_activity),
        .enabled      (enabled),
        .active_mode  (active_mode),
        .pend_mode    (pend_mode)
    );

    can_irq_flags #(.DATA_W(DATA_W)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .active_mode (active_mode),
        .tx_done     (tx_done),
        .rx_done     (rx_done),
        .clr_wr      (clr_wr),
        .clr_mask    (wdata),
        .flags       (flags)
    );

    assign status_word = status_bits(active_mode);

    can_reg_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_read (
        .addr        (addr),
        .enabled     (enabled),
        .pend_mode   (pend_mode),
        .status_word (status_word),
        .flags       (flags),
        .rdata       (rdata)
    );

    assign tx_permit  = (active_mode == OPM_NORMAL) || (active_mode == OPM_LOOP);
    assign loop_route = (active_mode == OPM_LOOP);
    assign irq        = flags.tx || flags.rx;

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk
    import can_ctl_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              tx_done,
    input logic              bus_activity,
    input logic              enabled,
    input op_mode_e          active_mode,
    input op_mode_e          pend_mode,
    input flag_set_t         flags,
    input logic [15:0]       status_word,
    input logic              tx_permit,
    input logic              irq
);

    logic ctrl_w;
    assign ctrl_w = wr_en && (addr == ADDR_W'(OFS_CTRL));

    assert_status_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status_word));

    assert_disable_to_cfg_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_w && !wdata[EN_BIT] |=> (active_mode == OPM_CFG) && !enabled);

    assert_mode_locked_R5: assert property (@(posedge clk) disable iff (rst)
        enabled && wr_en && (addr == ADDR_W'(OFS_MODE)) |=> $stable(pend_mode));

    assert_sleep_wake_R6: assert property (@(posedge clk) disable iff (rst)
        (active_mode == OPM_SLEEP) && bus_activity && !ctrl_w |=> active_mode == OPM_NORMAL);

    assert_loop_both_R8: assert property (@(posedge clk) disable iff (rst)
        (active_mode == OPM_LOOP) && tx_done |=> flags.tx && flags.rx);

    assert_snoop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (active_mode == OPM_SNOOP) |-> !tx_permit);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (active_mode == OPM_NORMAL) && tx_done |=> flags.tx);

    assert_irq_or_R12: assert property (@(posedge clk) disable iff (rst)
        irq == (flags.tx || flags.rx));

endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .tx_done      (tx_done),
    .bus_activity (bus_activity),
    .enabled      (enabled),
    .active_mode  (active_mode),
    .pend_mode    (pend_mode),
    .flags        (flags),
    .status_word  (status_word),
    .tx_permit    (tx_permit),
    .irq          (irq)
);

// File: tb/tb_can_mode_ctrl.sv
`timescale 1ns/1ps
module tb_can_mode_ctrl;

    localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_STAT = 8'h08,
                           A_FLAG = 8'h0C, A_FCLR = 8'h10;
    localparam int M_CFG = 0, M_NORM = 1, M_LOOP = 2, M_SNOOP = 3, M_SLEEP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_done = 1'b0, rx_done = 1'b0, bus_activity = 1'b0;
    logic        tx_permit, loop_route, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int  m_mode = M_CFG;
    int  m_pend = M_NORM;
    bit  m_en = 0;
    bit  m_ftx = 0, m_frx = 0;

    always #2 clk = ~clk;

    can_mode_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_done(tx_done), .rx_done(rx_done),
        .bus_activity(bus_activity), .tx_permit(tx_permit),
        .loop_route(loop_route), .irq(irq)
    );

    function automatic int req_of(input logic [31:0] d);
        if (d[0]) return M_SLEEP;
        if (d[1]) return M_LOOP;
        if (d[2]) return M_SNOOP;
        return M_NORM;
    endfunction

    function automatic logic [31:0] code_of(input int m);
        case (m)
            M_SLEEP: return 32'h1;
            M_LOOP:  return 32'h2;
            M_SNOOP: return 32'h4;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] stat_of(input int m);
        case (m)
            M_NORM:  return 32'h0000_0008;
            M_LOOP:  return 32'h0000_0002;
            M_SLEEP: return 32'h0000_0004;
            M_SNOOP: return 32'h0000_1000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        addr = A_STAT; #0.2;
        cmp({tag, " status R3"}, rdata, stat_of(m_mode));
        addr = A_FLAG; #0.2;
        cmp({tag, " flags R7"}, rdata, {27'd0, m_frx, 2'd0, m_ftx, 1'b0});
        addr = A_MODE; #0.2;
        cmp({tag, " mode readback R2"}, rdata, code_of(m_pend));
        addr = A_CTRL; #0.2;
        cmp({tag, " enable readback R4"}, rdata, {30'd0, m_en, 1'b0});
        cmp({tag, " irq R12"}, {31'd0, irq}, {31'd0, (m_ftx | m_frx)});
        cmp({tag, " tx_permit R9"}, {31'd0, tx_permit}, {31'd0, (m_mode == M_NORM || m_mode == M_LOOP)});
        cmp({tag, " loop_route R8"}, {31'd0, loop_route}, {31'd0, (m_mode == M_LOOP)});
    endtask

    task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input bit t, input bit r, input bit b, input string tag);
        bit acc_tx, acc_rx;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tx_done = t; rx_done = r; bus_activity = b;
        acc_tx = t && (m_mode == M_NORM || m_mode == M_LOOP);
        acc_rx = (r && (m_mode == M_NORM || m_mode == M_SLEEP || m_mode == M_SNOOP)) ||
                 (t && m_mode == M_LOOP);
        if (w && a == A_FCLR) begin
            if (d[1]) m_ftx = 0;
            if (d[4]) m_frx = 0;
        end
        if (acc_tx) m_ftx = 1;
        if (acc_rx) m_frx = 1;
        if (w && a == A_CTRL) begin
            if (!d[1]) m_mode = M_CFG;
            else if (!m_en) m_mode = m_pend;
            m_en = d[1];
        end else if (m_mode == M_SLEEP && b) begin
            m_mode = M_NORM;
        end
        if (w && a == A_MODE && !m_en) m_pend = req_of(d);
        @(posedge clk); #0.2;
        wr_en = 0; tx_done = 0; rx_done = 0; bus_activity = 0;
        check_all(tag);
    endtask

    task automatic enter(input logic [31:0] code, input string tag);
        step(1, A_CTRL, 32'h0, 0, 0, 0, {tag, " disable"});
        step(1, A_MODE, code, 0, 0, 0, {tag, " select"});
        step(1, A_CTRL, 32'h2, 0, 0, 0, {tag, " enable"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #0.2; check_all("R1 reset");

        // R7: config mode ignores strobes
        step(0, A_STAT, 0, 1, 1, 1, "R7 cfg ignores");
        // normal mode
        step(1, A_CTRL, 32'h2, 0, 0, 0, "R4 enable normal");
        step(0, A_STAT, 0, 1, 0, 0, "R7 tx normal");
        step(0, A_STAT, 0, 0, 1, 0, "R7 rx normal");
        step(1, A_FCLR, 32'h0, 0, 0, 0, "R10 zero clear");
        step(1, A_FCLR, 32'h2, 0, 0, 0, "R10 clear tx only");
        step(1, A_FCLR, 32'h10, 0, 1, 0, "R11 rx set wins");
        step(1, A_FCLR, 32'h12, 1, 0, 0, "R11 tx set wins");
        step(1, A_MODE, 32'h4, 0, 0, 0, "R5 locked write");
        step(1, A_FCLR, 32'hFFFF_FFFF, 0, 0, 0, "R10 clear all");
        // loopback
        enter(32'h2, "R8 loop");
        step(0, A_STAT, 0, 0, 1, 0, "R8 ext rx ignored");
        step(0, A_STAT, 0, 1, 0, 0, "R8 loop tx");
        step(1, A_FCLR, 32'h12, 0, 0, 0, "R10 clear both");
        // snoop
        enter(32'h4, "R9 snoop");
        step(0, A_STAT, 0, 1, 0, 0, "R9 tx ignored");
        step(0, A_STAT, 0, 0, 1, 0, "R9 snoop rx");
        step(1, A_FCLR, 32'h10, 0, 0, 0, "R10 clear rx");
        // sleep, odd code 0x03 decodes to sleep
        enter(32'h3, "R2 code3 sleep");
        step(0, A_STAT, 0, 1, 0, 0, "R6 sleep no tx");
        step(0, A_STAT, 0, 0, 1, 1, "R6 wake with rx");
        enter(32'h6, "R2 code6 loop");
        enter(32'h0, "R2 normal");
        step(1, A_CTRL, 32'h0, 0, 0, 0, "R4 disable");

        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [31:0] d;
            sel = $urandom_range(0, 9);
            d = $urandom;
            case (sel)
                0: step(1, A_CTRL, {d[31:2], $urandom_range(0, 3) != 0, d[0]},
                        d[5], d[6], d[7], "R4 rand ctrl");
                1: step(1, A_MODE, d, d[5], d[6], d[7], "R5 rand mode");
                2: step(1, A_FCLR, d, d[8], d[9], d[10], "R11 rand clear");
                3: step(1, A_MODE, {29'd0, d[2:0]}, 0, 0, 0, "R2 rand code");
                default: step(0, A_STAT, 0, d[0] & d[1], d[2] & d[3], d[4] & d[5] & d[6],
                        "R6 rand strobes");
            endcase
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule